// File: doc/BRIEF.md
# Printer Port Register Block with Emulated Handshake

This block gives a host a byte-wide register window onto a legacy printer port. No real printer is attached, so the block emulates the printer side itself. The host writes a byte into an output latch and then pulses the strobe bit in the control register. A rising strobe moves the latched byte onto an output byte stream. The host follows the printer's busy and acknowledge lines by polling the status register, and each status read steps that handshake forward. The block raises a level interrupt when the host drops strobe while the port is selected, provided interrupts were already enabled in the stored control value.

The bus is synchronous. Each cycle carries at most one access, with a 3-bit offset, a write enable, a read enable and byte-wide data in each direction. Read data is registered and appears one cycle after the read. An input byte latch is loaded from a valid/ready input stream, and the host can read it back when the direction bit is set. The output stream uses valid/ready and has a single holding slot.

Back-pressure works as follows. An offered byte stays on `out_data` with `out_valid` high until `out_ready` is seen high at a clock edge. If a new send is triggered while the slot is still full and `out_ready` is low, that new byte is dropped. The input stream never stalls: `in_ready` is always high.

Top module: `lpt_port`

## Requirements
- R1: Only `addr[2:0]` is decoded. Offset 0 is data, offset 1 is status and offset 2 is control. Reads of offsets 3 to 7 return 0xFF. Writes to offset 1 and to offsets 3 to 7 change no register.
- R2: After reset the output latch and the input latch both hold 0xFF, status is 0xD9, control is 0xCC, `irq` is 0, `out_valid` is 0 and `rdata` is 0xFF.
- R3: Every control write is stored with bits 7 and 6 forced to 1, and reading offset 2 returns the stored value.
- R4: A control write with bit 2 (init) at 0 sets status to 0xD8.
- R5: A control write with init=1, select (bit 3)=1 and strobe (bit 0)=1 clears status bit 7 (busy). The output latch is sent on the output stream only when the previously stored strobe bit was 0.
- R6: A control write with init=1, select=1 and strobe=0 makes the interrupt pending, but only if bit 4 (interrupt enable) of the previously stored control value is 1. `irq` equals the pending flag and holds until it is cleared.
- R7: A status read returns the status as it was before the read, and clears the pending interrupt.
- R8: A status read taken while busy (bit 7) is 0 and the stored strobe is 0 advances the handshake. If ack (bit 6) is 1 it is cleared; otherwise ack and busy are both set to 1.
- R9: A data read returns the input latch when control bit 5 (direction) is 1, and the output latch otherwise. The input latch loads `in_data` on each cycle with `in_valid` high.
- R10: A sent byte is held on `out_data` with `out_valid` high until accepted by `out_ready`. A send triggered while the slot is full and `out_ready` is low is dropped.
- R11: `rdata` updates in the cycle after a read and holds otherwise. When `wr_en` and `rd_en` are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, equal to the pending flag |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input stream ready, always 1 |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted by the sink |
| out_data | output | 8 | Output byte |

## Verification
Some rules are checked by the assertions on every cycle:
- an init-low control write forces 0xD8;
- a qualifying strobe write clears busy;
- a status read drops `irq`;
- a stalled output byte stays put;
- every new output byte traces back to a strobe-high control write.

Other behaviour only the directed scenarios can show. This covers the order of the ack/busy steps across several polls, the rule that interrupt enable comes from the previously stored control value, the dropping of a second send under back-pressure, and the data values returned by each offset and direction.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STROBE = 0;
  localparam int C_INIT   = 2;
  localparam int C_SELECT = 3;
  localparam int C_IRQEN  = 4;
  localparam int C_DIR    = 5;
  // status bit positions
  localparam int S_ACK    = 6;
  localparam int S_BUSY   = 7;

  localparam byte_t RST_LATCH   = 8'hFF;
  localparam byte_t RST_STATUS  = 8'hD9;
  localparam byte_t RST_CTRL    = 8'hCC;
  localparam byte_t INIT_STATUS = 8'hD8;
  localparam byte_t CTRL_FORCE  = 8'hC0;
  localparam byte_t IDLE_READ   = 8'hFF;
endpackage

// File: rtl/lpt_ctrl_regs.sv
module lpt_ctrl_regs
  import lpt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_we,
  input  logic  dat_we,
  input  byte_t wdata,
  input  logic  in_load,
  input  byte_t in_data,
  output byte_t ctl_q,
  output byte_t dout_q,
  output byte_t din_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= RST_CTRL;
      dout_q <= RST_LATCH;
      din_q  <= RST_LATCH;
    end else begin
      if (ctl_we)  ctl_q  <= wdata | CTRL_FORCE;
      if (dat_we)  dout_q <= wdata;
      if (in_load) din_q  <= in_data;
    end
  end

  // R3: bits 7:6 of a stored control value are always set once written
  p_ctl_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q[7:6] == 2'b11) && (ctl_q[5:0] == $past(wdata[5:0])));
endmodule

// File: rtl/lpt_handshake.sv
module lpt_handshake
  import lpt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_we,
  input  byte_t wdata,
  input  byte_t ctl_q,
  input  logic  stat_rd,
  output byte_t status_q,
  output logic  irq,
  output logic  send
);
  logic pend_q;
  logic sel_ok;

  assign sel_ok = ctl_we && wdata[C_INIT] && wdata[C_SELECT];
  assign send   = sel_ok && wdata[C_STROBE] && !ctl_q[C_STROBE];
  assign irq    = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= RST_STATUS;
      pend_q   <= 1'b0;
    end else if (ctl_we) begin
      if (!wdata[C_INIT]) begin
        status_q <= INIT_STATUS;
      end else if (wdata[C_SELECT]) begin
        if (wdata[C_STROBE])       status_q[S_BUSY] <= 1'b0;
        else if (ctl_q[C_IRQEN])   pend_q <= 1'b1;
      end
    end else if (stat_rd) begin
      pend_q <= 1'b0;
      if (!status_q[S_BUSY] && !ctl_q[C_STROBE]) begin
        if (status_q[S_ACK]) begin
          status_q[S_ACK] <= 1'b0;
        end else begin
          status_q[S_ACK]  <= 1'b1;
          status_q[S_BUSY] <= 1'b1;
        end
      end
    end
  end

  p_init_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !wdata[C_INIT] |=> status_q == INIT_STATUS);

  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok && wdata[C_STROBE] |=> !status_q[S_BUSY]);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !irq);

  // R6: pending flag only rises after a qualifying strobe-low write
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sel_ok && !wdata[C_STROBE] && ctl_q[C_IRQEN]));
endmodule

// File: rtl/lpt_out_stream.sv
module lpt_out_stream #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         send,
  input  logic [W-1:0] byte_in,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic slot_free;
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (send && slot_free) begin
      out_valid <= 1'b1;
      out_data  <= byte_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/lpt_port.sv
module lpt_port
  import lpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic  ctl_we, dat_we, rd_go, stat_rd, send;
  byte_t ctl_q, dout_q, din_q, status_q;

  assign ctl_we   = wr_en && (addr == OFS_CTRL);
  assign dat_we   = wr_en && (addr == OFS_DATA);
  assign rd_go    = rd_en && !wr_en;
  assign stat_rd  = rd_go && (addr == OFS_STAT);
  assign in_ready = 1'b1;

  lpt_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .dat_we(dat_we),
    .wdata(wdata), .in_load(in_valid), .in_data(in_data),
    .ctl_q(ctl_q), .dout_q(dout_q), .din_q(din_q)
  );

  lpt_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wdata(wdata),
    .ctl_q(ctl_q), .stat_rd(stat_rd), .status_q(status_q),
    .irq(irq), .send(send)
  );

  lpt_out_stream #(.W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .send(send), .byte_in(dout_q),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= IDLE_READ;
    end else if (rd_go) begin
      unique case (addr)
        OFS_DATA: rdata <= ctl_q[C_DIR] ? din_q : dout_q;
        OFS_STAT: rdata <= status_q;
        OFS_CTRL: rdata <= ctl_q;
        default:  rdata <= IDLE_READ;
      endcase
    end
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata));

  p_send_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wr_en && addr == OFS_CTRL && wdata[C_STROBE]));
endmodule

// File: tb/lpt_port_bench.sv
`timescale 1ns/1ps
module lpt_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, in_data = '0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] rdata, out_data;
  logic       irq, in_ready, out_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpt_port u_lpt_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic take_one();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 rdata", rdata, 8'hFF);
    chk("R2 irq", {7'd0, irq}, 8'h00);
    chk("R2 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R2 in_ready", {7'd0, in_ready}, 8'h01);
    rd(3'd1, v); chk("R2 status", v, 8'hD9);
    rd(3'd2, v); chk("R2 control", v, 8'hCC);
    rd(3'd0, v); chk("R2 out latch", v, 8'hFF);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    rd(3'd3, v); chk("R1 offset3", v, 8'hFF);
    rd(3'd7, v); chk("R1 offset7", v, 8'hFF);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R1 status write ignored", v, 8'hD9);
    wr(3'd4, 8'h12);
    rd(3'd0, v); chk("R1 offset4 write ignored", v, 8'hFF);
    rd(3'd2, v); chk("R1 control untouched", v, 8'hCC);
  endtask

  task automatic t_ctrl_force();
    logic [7:0] v;
    wr(3'd2, 8'h0C);
    rd(3'd2, v); chk("R3 forced bits", v, 8'hCC);
    chk("R3 no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_send_handshake();
    logic [7:0] v;
    wr(3'd0, 8'hA5);
    rd(3'd0, v); chk("R9 out latch", v, 8'hA5);
    wr(3'd2, 8'hCD);
    chk("R5 send valid", {7'd0, out_valid}, 8'h01);
    chk("R5 send data", out_data, 8'hA5);
    rd(3'd1, v); chk("R5 busy cleared", v, 8'h59);
    rd(3'd1, v); chk("R8 no step while strobe high", v, 8'h59);
    take_one();
    chk("R10 accepted", {7'd0, out_valid}, 8'h00);
    wr(3'd2, 8'hCD);
    chk("R5 repeat strobe no send", {7'd0, out_valid}, 8'h00);
    wr(3'd2, 8'hCC);
    rd(3'd1, v); chk("R8 step1 read", v, 8'h59);
    rd(3'd1, v); chk("R8 ack cleared", v, 8'h19);
    rd(3'd1, v); chk("R8 ack busy set", v, 8'hD9);
    rd(3'd1, v); chk("R8 stays while busy", v, 8'hD9);
  endtask

  task automatic t_backpressure();
    wr(3'd0, 8'h11);
    wr(3'd2, 8'hCD);
    wr(3'd2, 8'hCC);
    wr(3'd0, 8'h22);
    wr(3'd2, 8'hCD);
    chk("R10 held valid", {7'd0, out_valid}, 8'h01);
    chk("R10 first byte kept", out_data, 8'h11);
    take_one();
    chk("R10 drained", {7'd0, out_valid}, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(3'd2, 8'hDC);
    chk("R6 enable taken from stored value", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'hDC);
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    @(negedge clk); @(negedge clk);
    chk("R6 irq level held", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R7 status before step", v, 8'h59);
    chk("R7 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] v;
    wr(3'd2, 8'hC8);
    rd(3'd1, v); chk("R4 init status", v, 8'hD8);
    rd(3'd2, v); chk("R4 control stored", v, 8'hC8);
  endtask

  task automatic t_dir_and_timing();
    logic [7:0] v;
    @(negedge clk); in_data = 8'h3C; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; in_data = 8'h00;
    wr(3'd2, 8'hEC);
    wr(3'd0, 8'h77);
    rd(3'd0, v); chk("R9 input latch", v, 8'h3C);
    @(negedge clk); addr = 3'd2; wdata = 8'hCC; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read dropped on write", rdata, 8'h3C);
    @(negedge clk);
    chk("R11 rdata holds", rdata, 8'h3C);
    rd(3'd0, v); chk("R11 write took effect", v, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_ctrl_force();
    t_send_handshake();
    t_backpressure();
    t_irq();
    t_init();
    t_dir_and_timing();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule